// File: doc/BRIEF.md
# Ring-Snooping Cache-Only Coherence Cell Controller

This block is the coherence controller of one cell in a cache-only memory system whose cells sit on a unidirectional slotted ring. It keeps a small table of data items. Each entry is free, or holds an item in one of three states: allocated but invalid, read-only copy, or exclusive owner. The local processor issues reads, writes and post-store commands through a request/acknowledge handshake. The controller answers hits locally. On a miss it places a request packet into the next empty ring slot and stalls the processor until the packet comes back. Ownership of an item is not fixed to any cell: it moves to whichever cell writes the item.

Every cycle the controller takes in one ring slot and passes one slot downstream, after one register stage. A packet from another cell is forwarded, and the cell may act on it on the way. An owner turns a passing read request into a response that carries its data. An ownership request strips local copies and collects the owner's data. A cell that has space for an item but no valid copy takes the data from a passing response or post-store, without having asked for it. Post-store copies are skipped while the cell has a miss of its own outstanding. A packet that reaches the cell that sent it is removed from the ring.

Top module: `coma_cell_ctrl`

## Requirements
- R1: After reset the ring output slot is empty, `cpu_ack` is low and no item is held, so the first read of any address issues a ring request.
- R2: A read that finds the item read-only or owned raises `cpu_ack` for exactly one cycle, on the clock edge that accepts the request, with the item's data on `cpu_rdata`. No ring packet is sent.
- R3: A read miss sends a packet with kind code 1 (read request), source equal to the cell ID and the item address. Kind codes are 0 none, 1 read request, 2 read response, 3 ownership request, 4 post-store. When a kind-2 packet with the cell's own source comes back, the controller acknowledges with its data one cycle later, installs the item read-only and removes the packet.
- R4: A write to an item the cell does not own sends a kind-3 packet. The write completes one cycle after that packet returns, and the cell then owns the item with the new data. A write to an owned item acknowledges on the accepting edge and sends nothing.
- R5: A kind-1 packet from another cell, for an item this cell owns, leaves one cycle later as kind 2 with the same source and address, the owner's data and the data-valid bit set. The owner keeps its copy.
- R6: A kind-1 packet for an item this cell does not own is forwarded unchanged one cycle later.
- R7: A kind-3 packet from another cell is forwarded. If this cell owns the item, it inserts its data and sets data-valid. A read-only or owned local copy becomes allocated-invalid, so a later read misses.
- R8: A passing kind-2 packet addressed to another cell is forwarded. If the item is allocated-invalid here, the data is installed read-only, so a later read hits. With no entry for the item, nothing is installed.
- R9: A post-store command on an owned item sends a kind-4 packet with the owner's data and acknowledges one cycle after that packet returns. On an item that is not owned, the command acknowledges on the accepting edge and sends nothing.
- R10: A passing kind-4 packet installs its data read-only into an allocated-invalid entry if the cell has no miss outstanding. While a miss is outstanding, the entry stays invalid.
- R11: A packet carrying this cell's source is never forwarded. A returning kind-1 packet that no owner converted is sent again in the next empty slot.
- R12: A pending packet is injected only into an empty input slot. Passing packets keep their slot and are forwarded first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | Request is a write |
| cpu_post | input | 1 | Request is a post-store command (overrides `cpu_we`) |
| cpu_addr | input | ADDR_W | Item address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| ring_in_vld | input | 1 | Upstream slot holds a packet |
| ring_in_kind | input | 3 | Packet kind code |
| ring_in_src | input | CELL_W | Cell that sent the packet |
| ring_in_addr | input | ADDR_W | Item address of the packet |
| ring_in_data | input | DATA_W | Data word of the packet |
| ring_in_dv | input | 1 | Data word of the packet is valid |
| ring_out_vld | output | 1 | Downstream slot holds a packet |
| ring_out_kind | output | 3 | Packet kind code |
| ring_out_src | output | CELL_W | Cell that sent the packet |
| ring_out_addr | output | ADDR_W | Item address of the packet |
| ring_out_data | output | DATA_W | Data word of the packet |
| ring_out_dv | output | 1 | Data word of the packet is valid |

## Verification
The assertions rely on a well-behaved processor and ring. The processor holds a request with its fields stable until the acknowledge and drops it right after. Packets from other cells never carry this cell's source, and at most one cell owns an item. The bench plays the rest of the ring and follows all of these rules. It returns every packet this cell sends, and it plays a consistent owner when it converts requests. It only sends packets that fit the item states it has set up.

// File: rtl/coma_pkg.sv
package coma_pkg;
  typedef enum logic [2:0] {
    PK_NONE   = 3'd0,
    PK_RDREQ  = 3'd1,
    PK_RDRSP  = 3'd2,
    PK_OWNREQ = 3'd3,
    PK_POST   = 3'd4
  } pkt_kind_e;

  typedef enum logic [1:0] {
    LS_FREE = 2'd0,
    LS_INV  = 2'd1,
    LS_RO   = 2'd2,
    LS_OWN  = 2'd3
  } line_state_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cell_fsm_e;
endpackage

// File: rtl/coma_line_table.sv
module coma_line_table
  import coma_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_match,
  output logic [IDX_W-1:0]  cpu_idx,
  output line_state_e       cpu_state,
  output logic [DATA_W-1:0] cpu_data,
  input  logic [ADDR_W-1:0] rng_addr,
  output logic              rng_match,
  output logic [IDX_W-1:0]  rng_idx,
  output line_state_e       rng_state,
  output logic [DATA_W-1:0] rng_data,
  output logic              vic_ok,
  output logic [IDX_W-1:0]  vic_idx,
  input  logic              f_we,
  input  logic [IDX_W-1:0]  f_idx,
  input  logic [ADDR_W-1:0] f_addr,
  input  line_state_e       f_state,
  input  logic              f_dwe,
  input  logic [DATA_W-1:0] f_data,
  input  logic              r_we,
  input  logic [IDX_W-1:0]  r_idx,
  input  line_state_e       r_state,
  input  logic              r_dwe,
  input  logic [DATA_W-1:0] r_data
);
  line_state_e       st  [ENTRIES];
  logic [ADDR_W-1:0] tag [ENTRIES];
  logic [DATA_W-1:0] mem [ENTRIES];

  always_comb begin
    cpu_match = 1'b0;
    cpu_idx   = '0;
    rng_match = 1'b0;
    rng_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!cpu_match && st[i] != LS_FREE && tag[i] == cpu_addr) begin
        cpu_match = 1'b1;
        cpu_idx   = IDX_W'(i);
      end
      if (!rng_match && st[i] != LS_FREE && tag[i] == rng_addr) begin
        rng_match = 1'b1;
        rng_idx   = IDX_W'(i);
      end
    end
  end

  assign cpu_state = cpu_match ? st[cpu_idx] : LS_FREE;
  assign cpu_data  = mem[cpu_idx];
  assign rng_state = rng_match ? st[rng_idx] : LS_FREE;
  assign rng_data  = mem[rng_idx];

  // victim order: free slot, then invalid copy, then read-only copy; owners stay
  always_comb begin
    vic_ok  = 1'b0;
    vic_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!vic_ok && st[i] == LS_FREE) begin vic_ok = 1'b1; vic_idx = IDX_W'(i); end
    for (int i = 0; i < ENTRIES; i++)
      if (!vic_ok && st[i] == LS_INV) begin vic_ok = 1'b1; vic_idx = IDX_W'(i); end
    for (int i = 0; i < ENTRIES; i++)
      if (!vic_ok && st[i] == LS_RO) begin vic_ok = 1'b1; vic_idx = IDX_W'(i); end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st[g]  <= LS_FREE;
        tag[g] <= '0;
      end else if (f_we && f_idx == IDX_W'(g)) begin
        st[g]  <= f_state;
        tag[g] <= f_addr;
      end else if (r_we && r_idx == IDX_W'(g)) begin
        st[g]  <= r_state;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (f_we && f_dwe)
      mem[f_idx] <= f_data;
    if (r_we && r_dwe && !(f_we && f_idx == r_idx))
      mem[r_idx] <= r_data;
  end
endmodule

// File: rtl/coma_snoop.sv
module coma_snoop
  import coma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  pkt_kind_e         in_kind,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_dv,
  input  logic              hit,
  input  line_state_e       st,
  input  logic [DATA_W-1:0] line_data,
  input  logic              busy,
  output pkt_kind_e         out_kind,
  output logic [DATA_W-1:0] out_data,
  output logic              out_dv,
  output logic              upd_we,
  output line_state_e       upd_state,
  output logic              upd_dwe,
  output logic [DATA_W-1:0] upd_data
);
  always_comb begin
    out_kind  = in_kind;
    out_data  = in_data;
    out_dv    = in_dv;
    upd_we    = 1'b0;
    upd_state = st;
    upd_dwe   = 1'b0;
    upd_data  = in_data;
    case (in_kind)
      PK_RDREQ: if (hit && st == LS_OWN) begin
        out_kind = PK_RDRSP;
        out_data = line_data;
        out_dv   = 1'b1;
      end
      PK_RDRSP: if (hit && st == LS_INV) begin
        upd_we    = 1'b1;
        upd_state = LS_RO;
        upd_dwe   = 1'b1;
      end
      PK_OWNREQ: if (hit && st == LS_OWN) begin
        out_data  = line_data;
        out_dv    = 1'b1;
        upd_we    = 1'b1;
        upd_state = LS_INV;
      end else if (hit && st == LS_RO) begin
        upd_we    = 1'b1;
        upd_state = LS_INV;
      end
      PK_POST: if (hit && st == LS_INV && !busy) begin
        upd_we    = 1'b1;
        upd_state = LS_RO;
        upd_dwe   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coma_cell_ctrl.sv
module coma_cell_ctrl
  import coma_pkg::*;
#(
  parameter int CELL_ID = 3,
  parameter int CELL_W  = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_post,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ring_in_vld,
  input  logic [2:0]        ring_in_kind,
  input  logic [CELL_W-1:0] ring_in_src,
  input  logic [ADDR_W-1:0] ring_in_addr,
  input  logic [DATA_W-1:0] ring_in_data,
  input  logic              ring_in_dv,
  output logic              ring_out_vld,
  output logic [2:0]        ring_out_kind,
  output logic [CELL_W-1:0] ring_out_src,
  output logic [ADDR_W-1:0] ring_out_addr,
  output logic [DATA_W-1:0] ring_out_data,
  output logic              ring_out_dv
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CELL_W-1:0] MY_ID = CELL_W'(CELL_ID);

  cell_fsm_e         fsm;
  logic              inj_pend;
  pkt_kind_e         pend_kind;
  logic [IDX_W-1:0]  pend_idx;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;

  logic              cpu_match, rng_match, vic_ok;
  logic [IDX_W-1:0]  cpu_idx, rng_idx, vic_idx;
  line_state_e       cpu_state, rng_state;
  logic [DATA_W-1:0] cpu_data, rng_data;

  logic              f_we, f_dwe;
  logic [IDX_W-1:0]  f_idx;
  line_state_e       f_state;
  logic [DATA_W-1:0] f_data;

  pkt_kind_e         sn_kind;
  logic [DATA_W-1:0] sn_data, sn_upd_data;
  logic              sn_dv, sn_upd_we, sn_upd_dwe;
  line_state_e       sn_upd_state;

  logic own_pkt, fgn_pkt, busy, accept;
  logic rd_hit, wr_hit, post_own, post_nop, miss, inject;
  logic ret_rd, ret_req, ret_own, ret_post;
  logic [IDX_W-1:0] miss_idx;

  assign own_pkt  = ring_in_vld && ring_in_src == MY_ID;
  assign fgn_pkt  = ring_in_vld && !own_pkt;
  assign busy     = fsm != ST_IDLE;
  assign accept   = !busy && cpu_req && !cpu_ack && !(fgn_pkt && ring_in_addr == cpu_addr);
  assign rd_hit   = accept && !cpu_post && !cpu_we && (cpu_state == LS_RO || cpu_state == LS_OWN);
  assign wr_hit   = accept && !cpu_post && cpu_we && cpu_state == LS_OWN;
  assign post_own = accept && cpu_post && cpu_state == LS_OWN;
  assign post_nop = accept && cpu_post && cpu_state != LS_OWN;
  assign miss     = accept && !cpu_post && !rd_hit && !wr_hit && (cpu_match || vic_ok);
  assign miss_idx = cpu_match ? cpu_idx : vic_idx;
  assign ret_rd   = own_pkt && busy && ring_in_kind == PK_RDRSP;
  assign ret_req  = own_pkt && busy && ring_in_kind == PK_RDREQ;
  assign ret_own  = own_pkt && busy && ring_in_kind == PK_OWNREQ;
  assign ret_post = own_pkt && busy && ring_in_kind == PK_POST;
  assign inject   = inj_pend && !ring_in_vld;

  always_comb begin
    f_we    = 1'b0;
    f_idx   = pend_idx;
    f_state = LS_INV;
    f_dwe   = 1'b0;
    f_data  = pend_wdata;
    if (miss) begin
      f_we  = 1'b1;
      f_idx = miss_idx;
    end else if (wr_hit) begin
      f_we    = 1'b1;
      f_idx   = cpu_idx;
      f_state = LS_OWN;
      f_dwe   = 1'b1;
      f_data  = cpu_wdata;
    end else if (ret_rd) begin
      f_we    = 1'b1;
      f_state = LS_RO;
      f_dwe   = 1'b1;
      f_data  = ring_in_data;
    end else if (ret_own) begin
      f_we    = 1'b1;
      f_state = LS_OWN;
      f_dwe   = 1'b1;
    end
  end

  coma_line_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .cpu_addr(cpu_addr), .cpu_match(cpu_match), .cpu_idx(cpu_idx),
    .cpu_state(cpu_state), .cpu_data(cpu_data),
    .rng_addr(ring_in_addr), .rng_match(rng_match), .rng_idx(rng_idx),
    .rng_state(rng_state), .rng_data(rng_data),
    .vic_ok(vic_ok), .vic_idx(vic_idx),
    .f_we(f_we), .f_idx(f_idx), .f_addr(miss ? cpu_addr : (wr_hit ? cpu_addr : pend_addr)),
    .f_state(f_state), .f_dwe(f_dwe), .f_data(f_data),
    .r_we(fgn_pkt && sn_upd_we), .r_idx(rng_idx), .r_state(sn_upd_state),
    .r_dwe(sn_upd_dwe), .r_data(sn_upd_data)
  );

  coma_snoop #(.DATA_W(DATA_W)) u_snoop (
    .in_kind(pkt_kind_e'(ring_in_kind)), .in_data(ring_in_data), .in_dv(ring_in_dv),
    .hit(rng_match), .st(rng_state), .line_data(rng_data), .busy(busy),
    .out_kind(sn_kind), .out_data(sn_data), .out_dv(sn_dv),
    .upd_we(sn_upd_we), .upd_state(sn_upd_state), .upd_dwe(sn_upd_dwe), .upd_data(sn_upd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm           <= ST_IDLE;
      inj_pend      <= 1'b0;
      pend_kind     <= PK_NONE;
      pend_idx      <= '0;
      pend_addr     <= '0;
      pend_wdata    <= '0;
      cpu_ack       <= 1'b0;
      cpu_rdata     <= '0;
      ring_out_vld  <= 1'b0;
      ring_out_kind <= '0;
      ring_out_src  <= '0;
      ring_out_addr <= '0;
      ring_out_data <= '0;
      ring_out_dv   <= 1'b0;
    end else begin
      cpu_ack <= 1'b0;
      if (fgn_pkt) begin
        ring_out_vld  <= 1'b1;
        ring_out_kind <= sn_kind;
        ring_out_src  <= ring_in_src;
        ring_out_addr <= ring_in_addr;
        ring_out_data <= sn_data;
        ring_out_dv   <= sn_dv;
      end else if (inject) begin
        ring_out_vld  <= 1'b1;
        ring_out_kind <= pend_kind;
        ring_out_src  <= MY_ID;
        ring_out_addr <= pend_addr;
        ring_out_data <= pend_wdata;
        ring_out_dv   <= 1'b0;
        inj_pend      <= 1'b0;
      end else begin
        ring_out_vld  <= 1'b0;
      end
      if (rd_hit) begin
        cpu_ack   <= 1'b1;
        cpu_rdata <= cpu_data;
      end
      if (wr_hit || post_nop) cpu_ack <= 1'b1;
      if (miss || post_own) begin
        fsm        <= ST_WAIT;
        inj_pend   <= 1'b1;
        pend_kind  <= post_own ? PK_POST : (cpu_we ? PK_OWNREQ : PK_RDREQ);
        pend_idx   <= miss_idx;
        pend_addr  <= cpu_addr;
        pend_wdata <= post_own ? cpu_data : cpu_wdata;
      end
      if (ret_rd) begin
        cpu_ack   <= 1'b1;
        cpu_rdata <= ring_in_data;
      end
      if (ret_own) cpu_rdata <= pend_wdata;
      if (ret_rd || ret_own || ret_post) begin
        cpu_ack <= 1'b1;
        fsm     <= ST_IDLE;
      end
      if (ret_req) inj_pend <= 1'b1;
    end
  end

  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    inj_pend |-> fsm == ST_WAIT);

  a_r5_owner_converts: assert property (@(posedge clk) disable iff (rst)
    (fgn_pkt && ring_in_kind == PK_RDREQ && rng_state == LS_OWN)
      |=> (ring_out_vld && ring_out_kind == PK_RDRSP && ring_out_dv));

  a_r7_owner_supplies: assert property (@(posedge clk) disable iff (rst)
    (fgn_pkt && ring_in_kind == PK_OWNREQ && rng_state == LS_OWN)
      |=> (ring_out_vld && ring_out_kind == PK_OWNREQ && ring_out_dv));

  a_r11_own_removed: assert property (@(posedge clk) disable iff (rst)
    own_pkt |=> !ring_out_vld);

  a_r12_slot_kept: assert property (@(posedge clk) disable iff (rst)
    fgn_pkt |=> (ring_out_vld && ring_out_src == $past(ring_in_src)
                 && ring_out_addr == $past(ring_in_addr)));
endmodule

// File: tb/coma_cell_ctrl_bench.sv
`timescale 1ns/1ps
module coma_cell_ctrl_bench;
  localparam int ID = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req, cpu_we, cpu_post;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_ack;
  logic [15:0] cpu_rdata;
  logic        ri_vld, ri_dv, ro_vld, ro_dv;
  logic [2:0]  ri_kind, ro_kind;
  logic [4:0]  ri_src, ro_src;
  logic [7:0]  ri_addr, ro_addr;
  logic [15:0] ri_data, ro_data;

  int nvec = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  coma_cell_ctrl #(.CELL_ID(ID)) u_coma_cell_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_post(cpu_post),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .ring_in_vld(ri_vld), .ring_in_kind(ri_kind), .ring_in_src(ri_src),
    .ring_in_addr(ri_addr), .ring_in_data(ri_data), .ring_in_dv(ri_dv),
    .ring_out_vld(ro_vld), .ring_out_kind(ro_kind), .ring_out_src(ro_src),
    .ring_out_addr(ro_addr), .ring_out_data(ro_data), .ring_out_dv(ro_dv)
  );

  function automatic logic [63:0] pk(input logic v, input logic [2:0] k, input logic [4:0] s,
                                     input logic [7:0] a, input logic [15:0] d, input logic dv);
    return {30'd0, v, k, s, a, d, dv};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic v, input logic [2:0] k, input logic [4:0] s,
                         input logic [7:0] a, input logic [15:0] d, input logic dv);
    chk(req, pk(ro_vld, ro_kind, ro_src, ro_addr, ro_data, ro_dv), pk(v, k, s, a, d, dv));
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic put(input logic [2:0] k, input logic [4:0] s, input logic [7:0] a,
                     input logic [15:0] d, input logic dv);
    ri_vld = 1'b1; ri_kind = k; ri_src = s; ri_addr = a; ri_data = d; ri_dv = dv;
  endtask

  task automatic clear_ring(); ri_vld = 1'b0; ri_kind = 3'd0; ri_src = '0; ri_addr = '0; ri_data = '0; ri_dv = 1'b0; endtask

  task automatic start_req(input logic we, input logic post, input logic [7:0] a, input logic [15:0] d);
    cpu_req = 1'b1; cpu_we = we; cpu_post = post; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic end_req(); cpu_req = 1'b0; cpu_we = 1'b0; cpu_post = 1'b0; endtask

  task automatic read_miss(input logic [7:0] a, input logic [15:0] d, input string req);
    start_req(1'b0, 1'b0, a, 16'h0);
    step(); step();
    chk_out(req, 1'b1, 3'd1, 5'(ID), a, 16'h0, 1'b0);
    put(3'd2, 5'(ID), a, d, 1'b1);
    step();
    chk({req, " ack"}, {cpu_ack, cpu_rdata, ro_vld}, {1'b1, d, 1'b0});
    clear_ring(); end_req();
    step();
  endtask

  task automatic read_hit(input logic [7:0] a, input logic [15:0] d, input string req);
    start_req(1'b0, 1'b0, a, 16'h0);
    step();
    chk(req, {cpu_ack, cpu_rdata, ro_vld}, {1'b1, d, 1'b0});
    end_req();
    step();
    chk({req, " pulse"}, cpu_ack, 1'b0);
  endtask

  task automatic write_miss(input logic [7:0] a, input logic [15:0] d, input string req);
    start_req(1'b1, 1'b0, a, d);
    step(); step();
    chk_out(req, 1'b1, 3'd3, 5'(ID), a, d, 1'b0);
    put(3'd3, 5'(ID), a, 16'h0, 1'b1);
    step();
    chk({req, " ack"}, {cpu_ack, ro_vld}, {1'b1, 1'b0});
    clear_ring(); end_req();
    step();
  endtask

  task automatic pass_ownreq(input logic [7:0] a);
    put(3'd3, 5'd9, a, 16'h0, 1'b0);
    step();
    clear_ring();
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset ring", ro_vld, 1'b0);
    chk("R1 reset ack", cpu_ack, 1'b0);
    read_miss(8'h10, 16'h1234, "R1 R3 first read");
    read_hit(8'h10, 16'h1234, "R2 hit");
  endtask

  task automatic t_write();
    write_miss(8'h20, 16'hBEEF, "R4 write miss");
    read_hit(8'h20, 16'hBEEF, "R4 owned read");
    start_req(1'b1, 1'b0, 8'h20, 16'hCAFE);
    step();
    chk("R4 write hit", {cpu_ack, ro_vld}, {1'b1, 1'b0});
    end_req();
    step();
    read_hit(8'h20, 16'hCAFE, "R4 write hit data");
  endtask

  task automatic t_owner_answer();
    put(3'd1, 5'd7, 8'h20, 16'h0, 1'b0);
    step();
    chk_out("R5 convert", 1'b1, 3'd2, 5'd7, 8'h20, 16'hCAFE, 1'b1);
    clear_ring();
    step();
    read_hit(8'h20, 16'hCAFE, "R5 owner keeps");
  endtask

  task automatic t_forward();
    put(3'd1, 5'd7, 8'h30, 16'h1111, 1'b0);
    step();
    chk_out("R6 forward", 1'b1, 3'd1, 5'd7, 8'h30, 16'h1111, 1'b0);
    clear_ring();
    step();
  endtask

  task automatic t_invalidate();
    put(3'd3, 5'd9, 8'h20, 16'h0, 1'b0);
    step();
    chk_out("R7 owner data", 1'b1, 3'd3, 5'd9, 8'h20, 16'hCAFE, 1'b1);
    clear_ring();
    step();
    read_miss(8'h20, 16'h4444, "R7 owner lost");
    put(3'd3, 5'd9, 8'h10, 16'h0, 1'b0);
    step();
    chk_out("R7 ro forward", 1'b1, 3'd3, 5'd9, 8'h10, 16'h0, 1'b0);
    clear_ring();
    step();
    read_miss(8'h10, 16'h2222, "R7 ro lost");
  endtask

  task automatic t_snoop();
    pass_ownreq(8'h20);
    put(3'd2, 5'd7, 8'h20, 16'h5555, 1'b1);
    step();
    chk_out("R8 forward", 1'b1, 3'd2, 5'd7, 8'h20, 16'h5555, 1'b1);
    clear_ring();
    step();
    read_hit(8'h20, 16'h5555, "R8 captured");
    put(3'd2, 5'd7, 8'h40, 16'h6666, 1'b1);
    step();
    clear_ring();
    step();
    read_miss(8'h40, 16'h7777, "R8 no entry");
  endtask

  task automatic t_post();
    write_miss(8'h50, 16'h9999, "R9 setup");
    start_req(1'b0, 1'b1, 8'h50, 16'h0);
    step(); step();
    chk_out("R9 post out", 1'b1, 3'd4, 5'(ID), 8'h50, 16'h9999, 1'b0);
    put(3'd4, 5'(ID), 8'h50, 16'h9999, 1'b0);
    step();
    chk("R9 post ack", {cpu_ack, ro_vld}, {1'b1, 1'b0});
    clear_ring(); end_req();
    step();
    start_req(1'b0, 1'b1, 8'h10, 16'h0);
    step();
    chk("R9 post non-owner", {cpu_ack, ro_vld}, {1'b1, 1'b0});
    end_req();
    step();
  endtask

  task automatic t_post_rx();
    write_miss(8'h60, 16'h0001, "R10 setup a");
    pass_ownreq(8'h60);
    put(3'd4, 5'd9, 8'h60, 16'h7070, 1'b0);
    step();
    chk_out("R10 post forward", 1'b1, 3'd4, 5'd9, 8'h60, 16'h7070, 1'b0);
    clear_ring();
    step();
    read_hit(8'h60, 16'h7070, "R10 idle install");
    write_miss(8'h70, 16'h0002, "R10 setup b");
    pass_ownreq(8'h70);
    start_req(1'b0, 1'b0, 8'h78, 16'h0);
    step(); step();
    chk_out("R10 busy miss", 1'b1, 3'd1, 5'(ID), 8'h78, 16'h0, 1'b0);
    put(3'd4, 5'd9, 8'h70, 16'h8080, 1'b0);
    step();
    put(3'd2, 5'(ID), 8'h78, 16'h0101, 1'b1);
    step();
    chk("R10 busy ack", {cpu_ack, cpu_rdata}, {1'b1, 16'h0101});
    clear_ring(); end_req();
    step();
    read_miss(8'h70, 16'h9090, "R10 busy skip");
  endtask

  task automatic t_reissue();
    start_req(1'b0, 1'b0, 8'h80, 16'h0);
    step(); step();
    chk_out("R11 first", 1'b1, 3'd1, 5'(ID), 8'h80, 16'h0, 1'b0);
    put(3'd1, 5'(ID), 8'h80, 16'h0, 1'b0);
    step();
    chk("R11 removed", {ro_vld, cpu_ack}, {1'b0, 1'b0});
    clear_ring();
    step();
    chk_out("R11 reissue", 1'b1, 3'd1, 5'(ID), 8'h80, 16'h0, 1'b0);
    put(3'd2, 5'(ID), 8'h80, 16'hABCD, 1'b1);
    step();
    chk("R11 done", {cpu_ack, cpu_rdata}, {1'b1, 16'hABCD});
    clear_ring(); end_req();
    step();
  endtask

  task automatic t_wait_slot();
    start_req(1'b0, 1'b0, 8'h90, 16'h0);
    put(3'd2, 5'd5, 8'h31, 16'h0101, 1'b1);
    step();
    chk_out("R12 pass 1", 1'b1, 3'd2, 5'd5, 8'h31, 16'h0101, 1'b1);
    ri_data = 16'h0202;
    step();
    chk_out("R12 pass 2", 1'b1, 3'd2, 5'd5, 8'h31, 16'h0202, 1'b1);
    ri_data = 16'h0303;
    step();
    chk_out("R12 pass 3", 1'b1, 3'd2, 5'd5, 8'h31, 16'h0303, 1'b1);
    clear_ring();
    step();
    chk_out("R12 inject", 1'b1, 3'd1, 5'(ID), 8'h90, 16'h0, 1'b0);
    put(3'd2, 5'(ID), 8'h90, 16'h5A5A, 1'b1);
    step();
    chk("R12 ack", {cpu_ack, cpu_rdata}, {1'b1, 16'h5A5A});
    clear_ring(); end_req();
    step();
    read_hit(8'h90, 16'h5A5A, "R12 victim reuse");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1;
    end_req();
    cpu_addr = '0; cpu_wdata = '0;
    clear_ring();
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_write();
    t_owner_answer();
    t_forward();
    t_invalidate();
    t_snoop();
    t_post();
    t_post_rx();
    t_reissue();
    t_wait_slot();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule